// File: doc/BRIEF.md
# Programmable Output Cell with Selectable Feedback

This block is the per-pin output stage of a sequential programmable logic device. It takes a group of product terms from the AND plane and ORs them into one sum. That sum reaches the device pin either straight through, for combinational use, or through a D flip-flop, for counters and state machines. A configuration bit selects the path, and a second bit can invert the chosen value before it reaches the pin driver.

A separate output-enable term controls the pin driver. When the term is low the pin floats, and an external source may drive it, so the pin works as an input. The cell returns one feedback signal to the array. Its source is either the flip-flop output, which lets the present state set the next state, or the pin itself, which carries an external input back into the logic. Several cells whose registered feedback is wired into each other's product terms form a synchronous state machine.

Top module: `out_macrocell`

## Requirements
- R1: The sum is the logical OR of all `NUM_TERMS` bits of `prod_terms`. It is 1 exactly when at least one bit is 1.
- R2: The state flip-flop loads the sum on every rising edge of `clk` while `rst` is low.
- R3: A rising edge with `rst` high clears the flip-flop to 0, whatever the sum is. The reset is synchronous and active high.
- R4: With `oe_term` = 1, the value sent toward the pin is the flip-flop output when `cfg_registered` = 1. When `cfg_registered` = 0 it is the current sum, with no clock delay.
- R5: With `cfg_invert` = 1 the pin is driven with the complement of the value selected by R4. With `cfg_invert` = 0 it is driven with that value unchanged.
- R6: With `oe_term` = 0 the cell does not drive `pin`, and the pin carries whatever value an external source drives onto it.
- R7: With `cfg_fb_pin` = 0, `fb_out` equals the flip-flop output. With `cfg_fb_pin` = 1, `fb_out` equals the present value on `pin` in the same cycle, whether the cell or an external source drives it.
- R8: Two cells in registered mode with register feedback form a 2-bit binary counter. The low bit uses the product term ~fb0. The high bit uses fb1&~fb0 and ~fb1&fb0. After reset their pins read 0,1,2,3 and then 0 again on successive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state flip-flop updates on its rising edge |
| rst | input | 1 | Synchronous active-high clear of the state flip-flop |
| prod_terms | input | NUM_TERMS | Product terms from the AND plane, ORed inside the cell |
| oe_term | input | 1 | Output enable; 1 drives the pin, 0 leaves it floating |
| cfg_registered | input | 1 | 1 sends the flip-flop to the pin, 0 sends the sum |
| cfg_invert | input | 1 | 1 inverts the selected value before the pin driver |
| cfg_fb_pin | input | 1 | 1 takes feedback from the pin, 0 from the flip-flop |
| pin | inout | 1 | Device pin, driven or floating under `oe_term` |
| fb_out | output | 1 | Feedback signal returned to the AND plane |

## Verification
The cell holds a single bit of state, so a wrong flip-flop value shows up one clock after the bad edge. In registered mode it appears on `pin`. With register feedback selected it appears on `fb_out` even while the pin floats. In the counter a single corrupted bit breaks the 0,1,2,3 sequence on the next read, and every later count stays offset. Faults in the combinational path, such as a wrong mux choice, a missing inversion, or a driver left on while `oe_term` is low, are visible in the same cycle. A driver left on is caught by driving the pin from outside with the opposite value.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef struct packed {
        logic registered;
        logic invert;
        logic fb_from_pin;
    } mc_cfg_t;

    typedef struct packed {
        logic bit_q;
    } mc_state_t;

endpackage

// File: rtl/mc_sum_or.sv
module mc_sum_or #(
    parameter int NUM_TERMS = 4
) (
    input  logic [NUM_TERMS-1:0] terms_i,
    output logic                 sum_o
);
    localparam int CHAIN_W = NUM_TERMS + 1;

    logic [CHAIN_W-1:0] chain;

    assign chain[0] = 1'b0;

    for (genvar g = 0; g < NUM_TERMS; g++) begin : g_or
        assign chain[g+1] = chain[g] | terms_i[g];
    end

    assign sum_o = chain[CHAIN_W-1];
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sum_i,
    output logic bit_o
);
    mc_state_t st_d;
    mc_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bit_q = 1'b0;
        end else begin
            st_d.bit_q = sum_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bit_o = st_q.bit_q;
endmodule

// File: rtl/mc_out_path.sv
module mc_out_path
    import mc_pkg::*;
(
    input  mc_cfg_t cfg_i,
    input  logic    sum_i,
    input  logic    bit_i,
    input  logic    pin_i,
    output logic    drive_o,
    output logic    fb_o
);
    logic chosen;

    always_comb begin
        chosen  = cfg_i.registered ? bit_i : sum_i;
        drive_o = chosen ^ cfg_i.invert;
        fb_o    = cfg_i.fb_from_pin ? pin_i : bit_i;
    end
endmodule

// File: rtl/out_macrocell.sv
module out_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_TERMS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_TERMS-1:0] prod_terms,
    input  logic                 oe_term,
    input  logic                 cfg_registered,
    input  logic                 cfg_invert,
    input  logic                 cfg_fb_pin,
    inout  wire                  pin,
    output logic                 fb_out
);
    mc_cfg_t cfg;
    logic    sum_val;
    logic    state_bit;
    logic    drive_val;

    assign cfg.registered  = cfg_registered;
    assign cfg.invert      = cfg_invert;
    assign cfg.fb_from_pin = cfg_fb_pin;

    mc_sum_or #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .terms_i (prod_terms),
        .sum_o   (sum_val)
    );

    mc_state_reg u_state (
        .clk   (clk),
        .rst   (rst),
        .sum_i (sum_val),
        .bit_o (state_bit)
    );

    mc_out_path u_path (
        .cfg_i   (cfg),
        .sum_i   (sum_val),
        .bit_i   (state_bit),
        .pin_i   (pin),
        .drive_o (drive_val),
        .fb_o    (fb_out)
    );

    assign pin = oe_term ? drive_val : 1'bz;
endmodule

// File: rtl/out_macrocell_chk.sv
module out_macrocell_chk #(
    parameter int NUM_TERMS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_TERMS-1:0] prod_terms,
    input logic                 oe_term,
    input logic                 cfg_registered,
    input logic                 cfg_invert,
    input logic                 cfg_fb_pin,
    input logic                 pin,
    input logic                 fb_out,
    input logic                 state_bit
);
    // R2: the flip-flop follows the OR of the previous cycle's terms
    assert_reg_load_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> state_bit == $past(|prod_terms));

    // R4 and R5: registered path seen at the pin
    assert_reg_pin_R4: assert property (@(posedge clk) disable iff (rst)
        (oe_term && cfg_registered) |-> pin == (state_bit ^ cfg_invert));

    // R1, R4 and R5: combinational path seen at the pin
    assert_comb_pin_R5: assert property (@(posedge clk) disable iff (rst)
        (oe_term && !cfg_registered) |-> pin == ((|prod_terms) ^ cfg_invert));

    // R7: feedback taken from the register
    assert_fb_reg_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_fb_pin |-> fb_out == state_bit);

    // R7: feedback taken from the pin
    assert_fb_pin_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_fb_pin |-> fb_out == pin);
endmodule

bind out_macrocell out_macrocell_chk #(.NUM_TERMS(NUM_TERMS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .prod_terms     (prod_terms),
    .oe_term        (oe_term),
    .cfg_registered (cfg_registered),
    .cfg_invert     (cfg_invert),
    .cfg_fb_pin     (cfg_fb_pin),
    .pin            (pin),
    .fb_out         (fb_out),
    .state_bit      (state_bit)
);

// File: tb/test_out_macrocell.sv
`timescale 1ns/1ps
module test_out_macrocell;
    localparam int NT = 4;
    localparam int NV = 10;
    // fields: [11:8] terms, 7 oe, 6 registered, 5 invert, 4 fb_pin,
    //         3 ext_en, 2 ext_val, 1 exp_pin, 0 exp_fb
    localparam logic [11:0] VEC [NV] = '{
        12'b0001_1000_0010,
        12'b0000_1100_0011,
        12'b1000_1110_0010,
        12'b0000_1011_0011,
        12'b0100_0001_1000,
        12'b0010_0100_1001,
        12'b0000_0101_1111,
        12'b1111_1101_0000,
        12'b0000_0111_1111,
        12'b0110_1010_0000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NT-1:0] tv_terms = '0;
    logic oe_a = 1'b1, reg_a = 1'b1, inv_a = 1'b0, fbp_a = 1'b0;
    logic ext_en = 1'b0, ext_val = 1'b0;
    logic cnt_mode = 1'b0;
    logic done = 1'b0;
    int   n_run = 0;
    int   n_fail = 0;

    wire  pin_a;
    wire  pin_b;
    logic fb_a, fb_b;
    logic [NT-1:0] terms_a, terms_b;

    always #2.5 clk = ~clk;

    assign pin_a   = ext_en ? ext_val : 1'bz;
    assign terms_a = cnt_mode ? {3'b000, ~fb_a} : tv_terms;
    assign terms_b = {2'b00, (~fb_b & fb_a), (fb_b & ~fb_a)};

    out_macrocell #(.NUM_TERMS(NT)) i_out_macrocell (
        .clk(clk), .rst(rst), .prod_terms(terms_a), .oe_term(oe_a),
        .cfg_registered(reg_a), .cfg_invert(inv_a), .cfg_fb_pin(fbp_a),
        .pin(pin_a), .fb_out(fb_a)
    );

    out_macrocell #(.NUM_TERMS(NT)) i_out_macrocell_hi (
        .clk(clk), .rst(rst), .prod_terms(terms_b), .oe_term(1'b1),
        .cfg_registered(1'b1), .cfg_invert(1'b0), .cfg_fb_pin(1'b0),
        .pin(pin_b), .fb_out(fb_b)
    );

    task automatic check(input string what, input logic [1:0] got, input logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R3: reset clears the register even with the sum at 1
        tv_terms = 4'b1111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 reset pin", {1'b0, pin_a}, 2'd0);
        check("R3 reset fb", {1'b0, fb_a}, 2'd0);
        tv_terms = 4'b0000;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // table: inputs applied after the falling edge, sampled before the rising edge
        for (int i = 0; i < NV; i++) begin
            tv_terms = VEC[i][11:8];
            oe_a     = VEC[i][7];
            reg_a    = VEC[i][6];
            inv_a    = VEC[i][5];
            fbp_a    = VEC[i][4];
            ext_en   = VEC[i][3];
            ext_val  = VEC[i][2];
            #1;
            check($sformatf("row %0d pin R1 R4 R5 R6", i), {1'b0, pin_a}, {1'b0, VEC[i][1]});
            check($sformatf("row %0d fb R2 R7", i), {1'b0, fb_a}, {1'b0, VEC[i][0]});
            @(negedge clk);
        end

        // R8: two-bit counter through registered feedback
        ext_en = 1'b0; oe_a = 1'b1; reg_a = 1'b1; inv_a = 1'b0; fbp_a = 1'b0;
        cnt_mode = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 5; k++) begin
            check($sformatf("R8 count step %0d", k), {pin_b, pin_a}, 2'(k % 4));
            @(negedge clk);
        end

        // R6: pin released, external value must win in both directions
        oe_a = 1'b0; fbp_a = 1'b1; ext_en = 1'b1;
        ext_val = 1'b0;
        #1;
        check("R6 float ext0 pin", {1'b0, pin_a}, 2'd0);
        check("R7 float ext0 fb", {1'b0, fb_a}, 2'd0);
        ext_val = 1'b1;
        #1;
        check("R6 float ext1 pin", {1'b0, pin_a}, 2'd1);
        check("R7 float ext1 fb", {1'b0, fb_a}, 2'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule